// File: doc/BRIEF.md
# Hitless Reference Switch Phase Corrector

The block sits in front of a phase-locked loop. It turns one of two reference pulse trains into a "virtual reference" whose phase stays put when the selected reference changes. Phase is counted in ticks of a fast system clock. Both references and the loop feedback arrive as one-tick pulses with the same nominal period. The virtual reference is a one-tick pulse that fires a programmable number of ticks after each pulse of the selected reference.

When the requested reference changes, the block freezes the loop by raising a holdover flag and suppresses the virtual reference. It then counts the ticks from the next pulse of the new reference to the next feedback pulse. That count becomes the new delay, so the virtual reference lands exactly where the loop already is, and the block returns to normal mode. The result is the old delay plus the phase difference between the two references, so the offsets of successive switches accumulate in the delay.

An active-low clear input of sufficient width makes the accumulated delay walk back to zero. The walk runs at a bounded number of ticks per frame and goes along the shorter way around the reference period.

Top module: `hitless_ref_corrector`

## Requirements
- R1: After reset, delay_o is 0, holdover_o is 0 and ref_sel_o is 0 (reference A), so vref_o fires in the same cycle as each ref_a_i pulse.
- R2: In normal mode, when ref_sel_i differs from ref_sel_o (0 selects ref_a_i, 1 selects ref_b_i), holdover_o is 1 and ref_sel_o equals the new value one cycle later.
- R3: vref_o stays 0 while holdover_o is 1. Holdover ends in the cycle after the first fb_i pulse that comes at or after the first pulse of the new reference.
- R4: On leaving holdover, delay_o equals the number of ticks from that new-reference pulse to that fb_i pulse (0 when they coincide). This equals the previous delay plus the old-minus-new reference phase, modulo PERIOD, so repeated switches accumulate. delay_o is always below PERIOD.
- R5: In normal mode, vref_o is 1 in exactly the cycles where the tick count since the last selected-reference pulse equals delay_o. That count is 0 in the pulse cycle and wraps modulo PERIOD.
- R6: A change of ref_sel_i during holdover is not lost. If ref_sel_i still differs from ref_sel_o after the return, a new switch starts after exactly one cycle in normal mode.
- R7: A clear starts on the first clock in which clr_n_i is sampled high after at least CLR_MIN consecutive low samples. A shorter low pulse leaves delay_o unchanged.
- R8: While clearing, delay_o changes once every FRAME cycles and by at most STEP ticks. The first change comes FRAME cycles after the clock that started the clear.
- R9: The clear moves delay_o down when it is at most PERIOD/2, and otherwise up, wrapping to 0. Once delay_o is 0 it stays there.
- R10: A reference switch cancels a clear in progress. After the switch, delay_o keeps the measured value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System tick clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ref_a_i | input | 1 | One-tick pulse train of reference A |
| ref_b_i | input | 1 | One-tick pulse train of reference B |
| fb_i | input | 1 | One-tick feedback pulse from the loop output |
| ref_sel_i | input | 1 | Requested reference, 0 = A, 1 = B |
| clr_n_i | input | 1 | Active-low request to unwind the delay |
| vref_o | output | 1 | Virtual reference pulse to the loop |
| holdover_o | output | 1 | Switch in progress; loop must freeze |
| ref_sel_o | output | 1 | Reference currently in use |
| delay_o | output | PW | Accumulated delay in ticks |

## Verification
The bench drives a new reference that coincides with the feedback, one that sits one tick after it, and random phases. A design that measures from the wrong edge or drops a tick would leave delay_o off by one and make vref_o miss the feedback pulse. A request reversed during holdover must trigger a second switch that restores the original delay; a design that latches requests as pulses would lose it. Clear pulses of exactly CLR_MIN and one short of it are applied. The clear is started from delays below, at and just above half the period, which exposes a wrong tie rule, a wrong direction or a bad wrap through zero. One clear is interrupted by a switch, which catches a design that keeps unwinding the freshly measured delay.

// File: rtl/hitless_ref_corrector.sv
module hitless_ref_corrector #(
  parameter int PW      = 16,
  parameter int PERIOD  = 31250,
  parameter int FRAME   = 31250,
  parameter int STEP    = 1,
  parameter int CLR_MIN = 75
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ref_a_i,
  input  logic          ref_b_i,
  input  logic          fb_i,
  input  logic          ref_sel_i,
  input  logic          clr_n_i,
  output logic          vref_o,
  output logic          holdover_o,
  output logic          ref_sel_o,
  output logic [PW-1:0] delay_o
);
  localparam int CW = $clog2(CLR_MIN + 1);
  localparam int FW = $clog2(FRAME + 1);
  localparam logic [PW-1:0] P_W    = PW'(PERIOD);
  localparam logic [PW-1:0] P_M1   = PW'(PERIOD - 1);
  localparam logic [PW-1:0] HALF   = PW'(PERIOD / 2);
  localparam logic [PW-1:0] STEP_W = PW'(STEP);

  typedef enum logic [1:0] {S_NORM, S_WREF, S_WFB} st_t;

  st_t           st_q;
  logic          sel_q, clearing_q;
  logic [PW-1:0] ph_q, ph_now, delay_q;
  logic [CW-1:0] lo_cnt_q;
  logic [FW-1:0] fr_cnt_q;
  logic          ref_hit, load, clr_go, step;

  assign ref_hit = sel_q ? ref_b_i : ref_a_i;
  assign ph_now  = ref_hit ? '0 : ((ph_q == P_M1) ? '0 : ph_q + 1'b1);
  assign load    = fb_i && ((st_q == S_WFB) || (st_q == S_WREF && ref_hit));
  assign clr_go  = clr_n_i && (lo_cnt_q >= CW'(CLR_MIN)) && (st_q == S_NORM);
  assign step    = clearing_q && (st_q == S_NORM) && (fr_cnt_q == FW'(FRAME - 1)) && (delay_q != '0);

  assign vref_o     = (st_q == S_NORM) && (ph_now == delay_q);
  assign holdover_o = (st_q != S_NORM);
  assign ref_sel_o  = sel_q;
  assign delay_o    = delay_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= S_NORM;
      sel_q <= 1'b0;
      ph_q  <= '0;
    end else begin
      ph_q <= ph_now;
      case (st_q)
        S_NORM: if (ref_sel_i != sel_q) begin
          sel_q <= ref_sel_i;
          st_q  <= S_WREF;
        end
        S_WREF: if (ref_hit) st_q <= fb_i ? S_NORM : S_WFB;
        S_WFB:  if (fb_i) st_q <= S_NORM;
        default: st_q <= S_NORM;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      delay_q    <= '0;
      clearing_q <= 1'b0;
      lo_cnt_q   <= '0;
      fr_cnt_q   <= '0;
    end else begin
      if (!clr_n_i) lo_cnt_q <= (lo_cnt_q >= CW'(CLR_MIN)) ? lo_cnt_q : lo_cnt_q + 1'b1;
      else          lo_cnt_q <= '0;

      if (st_q != S_NORM)   clearing_q <= 1'b0;
      else if (clr_go)      clearing_q <= 1'b1;
      else if (delay_q == '0) clearing_q <= 1'b0;

      if (clr_go)          fr_cnt_q <= '0;
      else if (clearing_q) fr_cnt_q <= (fr_cnt_q == FW'(FRAME - 1)) ? '0 : fr_cnt_q + 1'b1;

      if (load) delay_q <= ph_now;
      else if (step) begin
        if (delay_q <= HALF) delay_q <= (delay_q > STEP_W) ? delay_q - STEP_W : '0;
        else                 delay_q <= ((P_W - delay_q) > STEP_W) ? delay_q + STEP_W : '0;
      end
    end
  end

  function automatic logic [PW-1:0] to_zero(input logic [PW-1:0] x);
    return (x <= HALF) ? x : P_W - x;
  endfunction

  function automatic logic [PW-1:0] ring_gap(input logic [PW-1:0] a, input logic [PW-1:0] b);
    logic [PW-1:0] d;
    d = (a >= b) ? a - b : b - a;
    return (d <= HALF) ? d : P_W - d;
  endfunction

  p_enter_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == S_NORM && ref_sel_i != sel_q) |=> (holdover_o && ref_sel_o == $past(ref_sel_i)));

  p_exit_on_fb_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(holdover_o) |-> $past(fb_i));

  p_delay_range_r4: assert property (@(posedge clk) disable iff (!rst_n)
    delay_q < P_W);

  p_clear_width_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(clearing_q) |-> ($past(lo_cnt_q) >= CW'(CLR_MIN)));

  p_step_bound_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == S_NORM && $past(st_q) == S_NORM) |-> (ring_gap(delay_q, $past(delay_q)) <= STEP_W));

  p_toward_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == S_NORM && $past(st_q) == S_NORM && delay_q != $past(delay_q))
      |-> (to_zero(delay_q) < to_zero($past(delay_q))));

  p_switch_stops_clear_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(holdover_o) |=> !clearing_q);
endmodule

// File: tb/test_hitless_ref_corrector.sv
`timescale 1ns/1ps
module test_hitless_ref_corrector;
  localparam int P = 40, FR = 20, ST = 3, CM = 6, PW = 16;

  logic clk = 1'b0, rst_n = 1'b0;
  logic ref_a_i = 1'b0, ref_b_i = 1'b0, fb_i = 1'b0, ref_sel_i = 1'b0, clr_n_i = 1'b1;
  logic vref_o, holdover_o, ref_sel_o;
  logic [PW-1:0] delay_o;

  int n_chk = 0, n_bad = 0, cnt = 0;
  int pa = 5, pb = 17, pf = 5, dmodel = 0;
  logic sel = 1'b0;

  always #2 clk = ~clk;

  hitless_ref_corrector #(.PW(PW), .PERIOD(P), .FRAME(FR), .STEP(ST), .CLR_MIN(CM)) i_hitless_ref_corrector (
    .clk(clk), .rst_n(rst_n), .ref_a_i(ref_a_i), .ref_b_i(ref_b_i), .fb_i(fb_i),
    .ref_sel_i(ref_sel_i), .clr_n_i(clr_n_i), .vref_o(vref_o), .holdover_o(holdover_o),
    .ref_sel_o(ref_sel_o), .delay_o(delay_o));

  initial forever begin
    @(negedge clk);
    cnt++;
    ref_a_i = ((cnt % P) == pa);
    ref_b_i = ((cnt % P) == pb);
    fb_i    = ((cnt % P) == pf);
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s act=%0d exp=%0d", tag, act, exp);
    end
  endtask

  task automatic tick;
    @(negedge clk);
    #1;
  endtask

  function automatic int md(input int x);
    return ((x % P) + P) % P;
  endfunction

  function automatic int psel();
    return sel ? pb : pa;
  endfunction

  function automatic int step_model(input int d);
    if (d <= P / 2) return (d > ST) ? d - ST : 0;
    return ((P - d) > ST) ? d + ST : 0;
  endfunction

  task automatic check_align(input string tag);
    int bad = 0, pulses = 0;
    repeat (2 * P) begin
      tick;
      if (vref_o !== fb_i) bad++;
      if (vref_o === 1'b1) pulses++;
    end
    chk(bad == 0 && pulses == 2, tag, bad * 100 + pulses, 2);
  endtask

  task automatic wait_hold(input string tag);
    int g = 0, q = 0;
    while (holdover_o === 1'b1 && g < 4 * P) begin
      if (vref_o !== 1'b0) q++;
      tick;
      g++;
    end
    chk(q == 0, {tag, " R3 vref quiet in holdover"}, q, 0);
    chk(holdover_o === 1'b0, {tag, " R3 holdover ends"}, int'(holdover_o), 0);
  endtask

  task automatic do_switch(input int pnew, input string tag);
    logic ns;
    int exp;
    ns = ~sel;
    if (ns) pb = pnew; else pa = pnew;
    exp = md(pf - pnew);
    ref_sel_i = ns;
    tick;
    chk(holdover_o === 1'b1 && ref_sel_o === ns, {tag, " R2 enter holdover"}, int'(holdover_o), 1);
    wait_hold(tag);
    chk(int'(delay_o) == exp, {tag, " R4 measured delay"}, int'(delay_o), exp);
    sel = ns;
    dmodel = exp;
    check_align({tag, " R5 vref on feedback"});
  endtask

  task automatic set_delay(input int t);
    do_switch(md(pf - t), "set");
  endtask

  task automatic do_clear(input int width, input bit accept);
    int d, nd, cyc, g, ch;
    clr_n_i = 1'b0;
    repeat (width) tick;
    clr_n_i = 1'b1;
    tick;
    if (!accept) begin
      ch = 0;
      repeat (3 * FR) begin
        tick;
        if (int'(delay_o) != dmodel) ch++;
      end
      chk(ch == 0, "R7 short clear ignored", ch, 0);
    end else begin
      d = dmodel; cyc = 0; g = 0;
      while (d != 0 && g < 60 * FR) begin
        tick; cyc++; g++;
        if (int'(delay_o) != d) begin
          nd = step_model(d);
          chk(int'(delay_o) == nd, "R9 clear direction and step", int'(delay_o), nd);
          chk(cyc == FR, "R8 one step per frame", cyc, FR);
          d = int'(delay_o);
          cyc = 0;
        end
      end
      chk(d == 0, "R9 clear reaches zero", d, 0);
      repeat (2 * FR) tick;
      chk(delay_o == 0, "R9 stays at zero", int'(delay_o), 0);
      dmodel = 0;
      pf = md(psel());
      check_align("R5 aligned after clear");
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog expired act=0 exp=1");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    int p;
    void'($urandom(32'd4711));
    repeat (3) tick;
    rst_n = 1'b1;
    tick;
    chk(delay_o == 0, "R1 reset delay", int'(delay_o), 0);
    chk(holdover_o === 1'b0, "R1 reset holdover", int'(holdover_o), 0);
    chk(ref_sel_o === 1'b0, "R1 reset select", int'(ref_sel_o), 0);
    check_align("R1 vref on ref A");

    do_switch(md(pf), "coincident");
    do_switch(md(pf + 1), "wrap");

    for (int i = 0; i < 12; i++) begin
      p = int'($urandom % P);
      do_switch(p, "random");
    end

    begin
      int orig, pnew, exp1;
      logic old;
      orig = dmodel; old = sel; pnew = md(psel() + 11);
      if (~old) pb = pnew; else pa = pnew;
      exp1 = md(pf - pnew);
      ref_sel_i = ~old;
      tick;
      ref_sel_i = old;
      wait_hold("pending first");
      chk(int'(delay_o) == exp1, "R6 first switch delay", int'(delay_o), exp1);
      tick;
      chk(holdover_o === 1'b1 && ref_sel_o === old, "R6 held request serviced", int'(holdover_o), 1);
      wait_hold("pending second");
      chk(int'(delay_o) == orig, "R6 R4 delay restored", int'(delay_o), orig);
      sel = old;
      dmodel = orig;
      check_align("R6 R5 aligned after pair");
    end

    set_delay(12);
    do_clear(CM - 1, 1'b0);
    do_clear(CM, 1'b1);
    set_delay(30);
    do_clear(CM, 1'b1);
    set_delay(20);
    do_clear(CM + 4, 1'b1);
    set_delay(21);
    do_clear(CM, 1'b1);

    begin
      int ch;
      set_delay(25);
      clr_n_i = 1'b0;
      repeat (CM) tick;
      clr_n_i = 1'b1;
      tick;
      repeat (FR) tick;
      chk(delay_o == 28, "R8 R9 first upward step", int'(delay_o), 28);
      dmodel = 28;
      pf = md(psel() + 28);
      do_switch(int'($urandom % P), "cancel");
      ch = 0;
      repeat (3 * FR) begin
        tick;
        if (int'(delay_o) != dmodel) ch++;
      end
      chk(ch == 0, "R10 switch cancels clear", ch, 0);
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule